// File: doc/BRIEF.md
# Remote DMA Byte-Port Engine

This block gives a host processor indirect access to a packet buffer RAM through a single data port. The host first sets a 16-bit start address and a 16-bit byte count, each split into a low byte and a high byte in separate registers. It then writes a command register whose three-bit operation field starts a read, starts a write, names a send (decoded but not carried out here), or aborts. After that, every access to the data port moves one byte, or two bytes in word mode, and advances a live address that the host can read back at any time.

When the last byte of the programmed count has moved, the engine stops and raises a completion flag in a status register. The host clears that flag by writing a one to it. A read transfer shows the byte at the current address on the data port at once, so the host needs no priming access. Data-port accesses outside an active transfer, or in the wrong direction, have no effect. The buffer RAM model sits inside the block.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset, the command register (offset 0) reads 0x21 (stop set, operation field 100), the status register (offset 7) reads 0x00, and the live address registers (offsets 5 and 6) read 0x00.
- R2: On page 0 (command bits 7:6 = 00), the start address low/high bytes (offsets 1 and 2) and the count low/high bytes (offsets 3 and 4) read back the last values written. On any other page, every offset except 0 reads 0x00 and ignores writes.
- R3: A command write whose bits 5:3 are 001 (read) or 010 (write) loads the live address from the start address and begins a transfer of the programmed count. The codes 011 (send) and 000 start no transfer and leave the live address unchanged.
- R4: A command write with bit 5 set stops an active transfer at once. It leaves the live address where it was and does not set the completion flag.
- R5: During a write transfer, each data-port write stores dport_wdata[7:0] at the live address, and the live address then increases by one.
- R6: During a read transfer, dport_rdata shows the byte at the live address with no wait cycle, upper byte zero in byte mode. Each data-port read advances the live address.
- R7: With configuration bit 0 (offset 8) set, each access moves two bytes: the low data byte at the live address and the high byte at the next address. The live address then steps by two, and an odd count is rounded up to the next even value when the command is issued.
- R8: When the final byte of the count moves, status bit 6 becomes 1 and the transfer ends.
- R9: A read or write command issued with a count of zero (after rounding) sets status bit 6 in the same cycle and moves no data.
- R10: Writing status with bit 6 = 1 clears the flag, and writing 0 there leaves it unchanged. If completion and a clear happen in the same cycle, the flag ends up set.
- R11: Data-port accesses made when no transfer is active, or in the direction opposite to the active one, change neither RAM nor the live address. dport_rdata is zero whenever no read transfer is active.
- R12: The live address wraps from 0xFFFF to 0x0000, and the RAM is indexed by its low address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| dport_rd | input | 1 | Data-port read access |
| dport_wr | input | 1 | Data-port write access |
| dport_wdata | input | 16 | Data-port write data (low byte only in byte mode) |
| dport_rdata | output | 16 | Data-port read data |

## Verification
The assertions take for granted that the host does not change the word-mode bit while a transfer is active. They also assume that a data-port access in the same cycle as a command write may be dropped. The stimulus changes configuration only while the engine is idle, and it never pairs a command write with a data-port access. The one deliberate overlap is a status clear in the same cycle as the completing access, which exercises the set-over-clear rule. The bench writes every RAM byte before any read transfer covers it, so the compared read data is always defined.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
    localparam int RDMA_AW = 16;

    localparam logic [3:0] REG_CMD   = 4'd0;
    localparam logic [3:0] REG_SA_LO = 4'd1;
    localparam logic [3:0] REG_SA_HI = 4'd2;
    localparam logic [3:0] REG_BC_LO = 4'd3;
    localparam logic [3:0] REG_BC_HI = 4'd4;
    localparam logic [3:0] REG_CA_LO = 4'd5;
    localparam logic [3:0] REG_CA_HI = 4'd6;
    localparam logic [3:0] REG_STAT  = 4'd7;
    localparam logic [3:0] REG_CFG   = 4'd8;

    localparam int         DONE_BIT  = 6;
    localparam logic [7:0] CMD_RESET = 8'h21;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_RD,
        OP_WR,
        OP_SEND,
        OP_ABORT
    } dma_op_e;

    function automatic dma_op_e decode_op(input logic [2:0] f);
        if (f[2]) return OP_ABORT;
        case (f[1:0])
            2'b00:   return OP_NONE;
            2'b01:   return OP_RD;
            2'b10:   return OP_WR;
            default: return OP_SEND;
        endcase
    endfunction
endpackage

// File: rtl/rdma_bufram.sv
module rdma_bufram #(
    parameter int RAM_AW = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic              we_hi,
    input  logic [RAM_AW-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata
);
    localparam int DEPTH = 1 << RAM_AW;

    logic [7:0]        mem [DEPTH];
    logic [RAM_AW-1:0] addr_nx;

    assign addr_nx = addr + RAM_AW'(1);
    assign rdata   = {mem[addr_nx], mem[addr]};

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata[7:0];
        if (we && we_hi) mem[addr_nx] <= wdata[15:8];
    end
endmodule

// File: rtl/rdma_xfer.sv
module rdma_xfer
    import rdma_pkg::*;
#(
    parameter int AW = RDMA_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  dma_op_e       cmd_op,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] byte_cnt,
    input  logic          word_mode,
    input  logic          dp_rd,
    input  logic          dp_wr,
    output logic [AW-1:0] cur_addr,
    output logic          active,
    output logic          dir_wr,
    output logic          fire,
    output logic          done_pulse
);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic          active;
        logic          dir_wr;
        logic [AW-1:0] cur;
        logic [CW-1:0] left;
    } xfer_t;

    xfer_t         q, d;
    logic [CW-1:0] step;
    logic [CW-1:0] cnt_rnd;

    always_comb begin
        d          = q;
        fire       = 1'b0;
        done_pulse = 1'b0;
        step       = word_mode ? CW'(2) : CW'(1);
        cnt_rnd    = {1'b0, byte_cnt} + CW'(word_mode & byte_cnt[0]);
        if (cmd_wr) begin
            case (cmd_op)
                OP_ABORT: d.active = 1'b0;
                OP_RD, OP_WR: begin
                    d.active   = (cnt_rnd != '0);
                    d.dir_wr   = (cmd_op == OP_WR);
                    d.cur      = start_addr;
                    d.left     = cnt_rnd;
                    done_pulse = (cnt_rnd == '0);
                end
                default: ;
            endcase
        end else if (q.active && (q.dir_wr ? dp_wr : dp_rd)) begin
            fire  = 1'b1;
            d.cur = q.cur + step[AW-1:0];
            if (q.left <= step) begin
                d.left     = '0;
                d.active   = 1'b0;
                done_pulse = 1'b1;
            end else begin
                d.left = q.left - step;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cur_addr = q.cur;
    assign active   = q.active;
    assign dir_wr   = q.dir_wr;

    p_abort_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_op == OP_ABORT) |=> (!active && cur_addr == $past(cur_addr)));

    p_fire_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !word_mode) |=> cur_addr == $past(cur_addr) + AW'(1));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_wr && !active) |=> $stable(cur_addr));

    p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse && !cmd_wr) |=> !active);
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
    import rdma_pkg::*;
#(
    parameter int RAM_AW = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        dport_rd,
    input  logic        dport_wr,
    input  logic [15:0] dport_wdata,
    output logic [15:0] dport_rdata
);
    localparam int AW = RDMA_AW;

    typedef struct packed {
        logic [7:0]    cmd;
        logic [AW-1:0] start;
        logic [AW-1:0] count;
        logic          word;
        logic          done;
    } regs_t;

    regs_t         q, d;
    logic          page0;
    logic          cmd_wr;
    logic          stat_clr;
    logic [AW-1:0] cur_addr;
    logic          xf_active;
    logic          xf_dir_wr;
    logic          xf_fire;
    logic          xf_done;
    logic [15:0]   ram_rdata;

    assign page0    = (q.cmd[7:6] == 2'b00);
    assign cmd_wr   = reg_wr && (reg_addr == REG_CMD);
    assign stat_clr = reg_wr && page0 && (reg_addr == REG_STAT) && reg_wdata[DONE_BIT];

    always_comb begin
        d = q;
        if (cmd_wr) begin
            d.cmd = reg_wdata;
        end else if (reg_wr && page0) begin
            case (reg_addr)
                REG_SA_LO: d.start[7:0]  = reg_wdata;
                REG_SA_HI: d.start[15:8] = reg_wdata;
                REG_BC_LO: d.count[7:0]  = reg_wdata;
                REG_BC_HI: d.count[15:8] = reg_wdata;
                REG_CFG:   d.word        = reg_wdata[0];
                default: ;
            endcase
        end
        if (xf_done)       d.done = 1'b1;
        else if (stat_clr) d.done = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.cmd <= CMD_RESET;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == REG_CMD) begin
            reg_rdata = q.cmd;
        end else if (page0) begin
            case (reg_addr)
                REG_SA_LO: reg_rdata = q.start[7:0];
                REG_SA_HI: reg_rdata = q.start[15:8];
                REG_BC_LO: reg_rdata = q.count[7:0];
                REG_BC_HI: reg_rdata = q.count[15:8];
                REG_CA_LO: reg_rdata = cur_addr[7:0];
                REG_CA_HI: reg_rdata = cur_addr[15:8];
                REG_STAT:  reg_rdata[DONE_BIT] = q.done;
                REG_CFG:   reg_rdata[0] = q.word;
                default: ;
            endcase
        end
    end

    rdma_xfer #(.AW(AW)) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .cmd_op     (decode_op(reg_wdata[5:3])),
        .start_addr (q.start),
        .byte_cnt   (q.count),
        .word_mode  (q.word),
        .dp_rd      (dport_rd),
        .dp_wr      (dport_wr),
        .cur_addr   (cur_addr),
        .active     (xf_active),
        .dir_wr     (xf_dir_wr),
        .fire       (xf_fire),
        .done_pulse (xf_done)
    );

    rdma_bufram #(.RAM_AW(RAM_AW)) u_ram (
        .clk   (clk),
        .we    (xf_fire && xf_dir_wr),
        .we_hi (q.word),
        .addr  (cur_addr[RAM_AW-1:0]),
        .wdata (dport_wdata),
        .rdata (ram_rdata)
    );

    always_comb begin
        dport_rdata = 16'h0000;
        if (xf_active && !xf_dir_wr)
            dport_rdata = q.word ? ram_rdata : {8'h00, ram_rdata[7:0]};
    end

    p_done_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xf_done |=> q.done);

    p_w1c_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !xf_done) |=> !q.done);

    p_abort_no_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && reg_wdata[5] && !q.done) |=> !q.done);
endmodule

// File: tb/rdma_port_engine_test.sv
module rdma_port_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        dport_rd = 1'b0;
    logic        dport_wr = 1'b0;
    logic [15:0] dport_wdata = '0;
    logic [15:0] dport_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rdma_port_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dport_rd(dport_rd),
        .dport_wr(dport_wr), .dport_wdata(dport_wdata), .dport_rdata(dport_rdata)
    );

    // behavioural reference model
    logic [7:0] m_cmd;
    int         m_start, m_cnt, m_cur, m_left;
    bit         m_word, m_done, m_act, m_wr;
    logic [7:0] bmem [0:1023];

    function automatic logic [15:0] m_dport();
        if (!m_act || m_wr) return 16'h0;
        if (m_word) return {bmem[(m_cur + 1) % 1024], bmem[m_cur % 1024]};
        return {8'h00, bmem[m_cur % 1024]};
    endfunction

    function automatic logic [7:0] m_reg(input int a);
        if (a == 0) return m_cmd;
        if (m_cmd[7:6] != 2'b00) return 8'h00;
        case (a)
            1: return m_start[7:0];
            2: return m_start[15:8];
            3: return m_cnt[7:0];
            4: return m_cnt[15:8];
            5: return m_cur[7:0];
            6: return m_cur[15:8];
            7: return m_done ? 8'h40 : 8'h00;
            8: return {7'b0, m_word};
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_reset();
        m_cmd = 8'h21; m_start = 0; m_cnt = 0; m_cur = 0; m_left = 0;
        m_word = 0; m_done = 0; m_act = 0; m_wr = 0;
    endtask

    task automatic m_clock();
        bit cmd_now, pg0, set, clr;
        int n, c;
        cmd_now = reg_wr && reg_addr == 0;
        pg0 = (m_cmd[7:6] == 2'b00);
        set = 0;
        clr = reg_wr && pg0 && reg_addr == 7 && reg_wdata[6] && !cmd_now;
        if (!cmd_now && m_act && (m_wr ? dport_wr : dport_rd)) begin
            n = m_word ? 2 : 1;
            if (m_wr) begin
                bmem[m_cur % 1024] = dport_wdata[7:0];
                if (n == 2) bmem[(m_cur + 1) % 1024] = dport_wdata[15:8];
            end
            m_cur = (m_cur + n) & 16'hFFFF;
            m_left -= n;
            if (m_left <= 0) begin m_act = 0; set = 1; end
        end
        if (cmd_now) begin
            m_cmd = reg_wdata;
            if (reg_wdata[5]) m_act = 0;
            else if (reg_wdata[5:3] == 3'b001 || reg_wdata[5:3] == 3'b010) begin
                c = (m_word && m_cnt % 2 == 1) ? m_cnt + 1 : m_cnt;
                m_cur = m_start; m_left = c; m_wr = (reg_wdata[5:3] == 3'b010);
                m_act = (c != 0); set = (c == 0);
            end
        end else if (reg_wr && pg0) begin
            case (reg_addr)
                1: m_start = (m_start & 16'hFF00) | reg_wdata;
                2: m_start = (m_start & 16'h00FF) | (int'(reg_wdata) << 8);
                3: m_cnt = (m_cnt & 16'hFF00) | reg_wdata;
                4: m_cnt = (m_cnt & 16'h00FF) | (int'(reg_wdata) << 8);
                8: m_word = reg_wdata[0];
                default: ;
            endcase
        end
        if (set) m_done = 1; else if (clr) m_done = 0;
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        m_clock();
        @(negedge clk);
        check("R6/R11 dport_rdata vs model", dport_rdata, m_dport());
    endtask

    task automatic wreg(input logic [3:0] a, input logic [7:0] v);
        reg_addr = a; reg_wr = 1; reg_wdata = v;
        step();
        reg_wr = 0;
    endtask

    task automatic dwr(input logic [15:0] v);
        dport_wr = 1; dport_wdata = v;
        step();
        dport_wr = 0;
    endtask

    task automatic drd();
        dport_rd = 1;
        step();
        dport_rd = 0;
    endtask

    task automatic creg(input logic [3:0] a, input string tag);
        reg_addr = a; #1;
        check(tag, {8'h0, reg_rdata}, {8'h0, m_reg(a)});
    endtask

    task automatic lreg(input logic [3:0] a, input logic [7:0] exp, input string tag);
        reg_addr = a; #1;
        check(tag, {8'h0, reg_rdata}, {8'h0, exp});
    endtask

    task automatic setup(input logic [15:0] sa, input logic [15:0] bc);
        wreg(4'd1, sa[7:0]); wreg(4'd2, sa[15:8]);
        wreg(4'd3, bc[7:0]); wreg(4'd4, bc[15:8]);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        m_reset();
        for (int i = 0; i < 1024; i++) bmem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset values
        lreg(4'd0, 8'h21, "R1 cmd reset");
        lreg(4'd7, 8'h00, "R1 status reset");
        lreg(4'd5, 8'h00, "R1 cur lo reset");
        lreg(4'd6, 8'h00, "R1 cur hi reset");

        // R2 split registers
        setup(16'h0010, 16'h0005);
        lreg(4'd1, 8'h10, "R2 start lo");
        lreg(4'd4, 8'h00, "R2 count hi");
        creg(4'd3, "R2 count lo");

        // R3/R5 byte write of 5 bytes
        wreg(4'd0, 8'h12);
        lreg(4'd5, 8'h10, "R3 write cmd loads address");
        for (int i = 0; i < 5; i++) begin
            dwr(16'hEE00 | (16'h00A0 + i));
            creg(4'd5, "R5 address advance");
        end
        lreg(4'd5, 8'h15, "R5 final address");
        lreg(4'd7, 8'h40, "R8 done after last byte");
        dwr(16'h0055);
        lreg(4'd5, 8'h15, "R11 access after done ignored");

        // R10 W1C
        wreg(4'd7, 8'h00);
        lreg(4'd7, 8'h40, "R10 zero write keeps flag");
        wreg(4'd7, 8'h40);
        lreg(4'd7, 8'h00, "R10 one write clears flag");

        // R6 read back, first data with no wait
        wreg(4'd0, 8'h0A);
        check("R6 first byte no wait", dport_rdata, 16'h00A0);
        for (int i = 0; i < 5; i++) begin
            check("R6 read data", dport_rdata, 16'h00A0 + i);
            drd();
        end
        lreg(4'd7, 8'h40, "R8 done after read");
        check("R11 idle rdata zero", dport_rdata, 16'h0000);
        wreg(4'd7, 8'h40);

        // R7 word mode, odd count rounded up
        wreg(4'd8, 8'h01);
        setup(16'h0020, 16'h0003);
        wreg(4'd0, 8'h12);
        dwr(16'hB2B1);
        lreg(4'd5, 8'h22, "R7 word step of two");
        lreg(4'd7, 8'h00, "R7 not done after first word");
        dwr(16'hB4B3);
        lreg(4'd7, 8'h40, "R7 rounded count done after two words");
        wreg(4'd7, 8'h40);
        wreg(4'd0, 8'h0A);
        check("R7 word read", dport_rdata, 16'hB2B1);
        drd();
        check("R7 second word read", dport_rdata, 16'hB4B3);
        drd();
        wreg(4'd7, 8'h40);
        wreg(4'd8, 8'h00);

        // R4 abort mid-transfer
        setup(16'h0040, 16'h000A);
        wreg(4'd0, 8'h12);
        dwr(16'h0011); dwr(16'h0022);
        wreg(4'd0, 8'h22);
        lreg(4'd5, 8'h42, "R4 address kept at abort");
        lreg(4'd7, 8'h00, "R4 abort no done");
        dwr(16'h0033);
        lreg(4'd5, 8'h42, "R11 write after abort ignored");
        drd();
        check("R11 rdata zero when idle", dport_rdata, 16'h0000);

        // R3 send and none codes
        wreg(4'd0, 8'h1A);
        lreg(4'd5, 8'h42, "R3 send no transfer");
        wreg(4'd0, 8'h02);
        lreg(4'd5, 8'h42, "R3 code 000 no transfer");

        // R9 zero count
        setup(16'h0080, 16'h0000);
        wreg(4'd0, 8'h12);
        lreg(4'd7, 8'h40, "R9 zero count done");
        dwr(16'h0077);
        lreg(4'd5, 8'h80, "R9 no data moved");
        wreg(4'd7, 8'h40);

        // R11 wrong direction
        setup(16'h0010, 16'h0002);
        wreg(4'd0, 8'h0A);
        dwr(16'h0099);
        lreg(4'd5, 8'h10, "R11 wrong direction ignored");
        check("R11 RAM untouched", dport_rdata, 16'h00A0);
        wreg(4'd0, 8'h22);

        // R2 paging
        wreg(4'd0, 8'h62);
        lreg(4'd1, 8'h00, "R2 page1 reads zero");
        wreg(4'd1, 8'h77);
        wreg(4'd0, 8'h22);
        lreg(4'd1, 8'h10, "R2 page1 write ignored");

        // R12 wrap plus R10 set beats clear
        setup(16'hFFFF, 16'h0002);
        wreg(4'd0, 8'h12);
        dwr(16'h00A1);
        lreg(4'd5, 8'h00, "R12 address wrapped lo");
        lreg(4'd6, 8'h00, "R12 address wrapped hi");
        reg_addr = 4'd7; reg_wr = 1; reg_wdata = 8'h40;
        dport_wr = 1; dport_wdata = 16'h00A2;
        step();
        reg_wr = 0; dport_wr = 0;
        lreg(4'd7, 8'h40, "R10 set wins over clear");
        lreg(4'd5, 8'h01, "R12 address after wrap");
        wreg(4'd7, 8'h40);
        wreg(4'd0, 8'h0A);
        check("R12 byte at top of RAM", dport_rdata, 16'h00A1);
        drd();
        check("R12 byte at RAM index 0", dport_rdata, 16'h00A2);
        drd();

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule